// File: doc/BRIEF.md
# Acknowledge-Chain Interrupter for a Seven-Level Priority Bus

This block is the slot-side half of a shared priority interrupt scheme. A local strobe marks a request as pending. The block then pulls low the one active-low request line chosen by a 3-bit level setting. A handler answers by lowering the acknowledge input and placing a level code on three address lines.

When that code equals this slot's level and a request is pending, the block claims the cycle. It drives a status/ID word onto the data lines and asserts the data acknowledge. It does not pass the acknowledge down the chain, so slots further along on the same level wait for a later cycle. In every other case the acknowledge is passed on to the next slot.

The request line is released as soon as the status/ID has been handed over. A level setting of zero turns the interrupter off.

The status/ID is assembled from three parts:
- the slot's logical address, in the low byte;
- a cause byte, which is either a raw code or one of several event encodings;
- for the 32-bit width only, a device word in the top half.

All of the block's outputs are registered against its clock, and it answers the acknowledge input one clock after it samples it.

Top module: `ackchain_interrupter`

## Requirements
- R1: While rstN is low, irqN is all ones, dtackN and iackOutN are high, dataOe is low and dataOut is zero.
- R2: A reqStrobe sampled high while iackInN is high makes the request pending from the next clock. While a request is pending and levelCfg is L (1..7), bit L-1 of irqN is low and every other bit is high. Further strobes never lower a second line.
- R3: On the first clock that iackInN is sampled low with a request pending, levelCfg nonzero and ackLevel equal to levelCfg, the block claims the cycle. From the next clock dtackN is low, dataOe is high, dataOut carries the status/ID, and iackOutN stays high.
- R4: On the first clock that iackInN is sampled low without the conditions of R3, the block forwards the acknowledge. This covers a level mismatch, a cycle with nothing pending, and a matching level with nothing pending. From the next clock iackOutN is low, dtackN stays high, and a pending request keeps its irqN line low.
- R5: Claiming a cycle clears the pending request, so irqN is all ones from the same clock that dtackN goes low.
- R6: The status/ID is assembled as follows. Bits 7:0 are logicalAddr. For DATA_W of 16 or 32, bits 15:8 are a cause byte selected by idKind: 0 gives causeCode; 1 gives a user event, {1, 0, eventCode[5:0]}; 2 gives 8'hFF (no cause given); 3 gives 8'hFD (request true). For DATA_W of 32, bits 31:16 are upperWord.
- R7: The clock after iackInN is sampled high, dtackN and iackOutN are high, dataOe is low and dataOut is zero.
- R8: A reqStrobe sampled while iackInN is low does not change irqN during that acknowledge cycle. It becomes pending on the clock where iackInN is sampled high again. A strobe on that releasing clock also becomes pending there.
- R9: With levelCfg equal to 0, irqN stays all ones and every acknowledge cycle is forwarded.
- R10: The claim-or-forward decision is made once, at the first low sample of iackInN. Later changes of ackLevel or reqStrobe within the same cycle leave dtackN and iackOutN unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| levelCfg | input | 3 | Interrupt level 1..7; 0 turns the interrupter off |
| logicalAddr | input | 8 | Logical address placed in status/ID bits 7:0 |
| causeCode | input | 8 | Raw cause byte, used when idKind is 0 |
| eventCode | input | 6 | User event code, used when idKind is 1 |
| idKind | input | 2 | Selects how the cause byte is formed |
| upperWord | input | 16 | Device word for status/ID bits 31:16 |
| reqStrobe | input | 1 | Local service request |
| iackInN | input | 1 | Acknowledge daisy-chain input, active low |
| ackLevel | input | 3 | Level being acknowledged, taken from the address lines |
| irqN | output | 7 | Active-low request lines; bit 0 is level 1 |
| iackOutN | output | 1 | Acknowledge daisy-chain output, active low |
| dtackN | output | 1 | Data acknowledge, active low |
| dataOut | output | DATA_W | Status/ID word, zero when not driven |
| dataOe | output | 1 | Data line enable |

## Verification
Two of the block's functions can fall in the same clock. The first is a local request strobe. The second is either the start of an acknowledge cycle or its release. The stimulus provokes both overlaps:
- a strobe on the very edge at which iackInN first drops with a matching level and nothing pending, which must be forwarded rather than claimed;
- strobes placed inside a claimed cycle and on the releasing edge.

The bench judges every clock against a behavioural reference model, which must show the deferred request appearing on irqN only after the release. Changes of ackLevel in the middle of a cycle check that the decision stays frozen.

// File: rtl/ackchain_pkg.sv
package ackchain_pkg;

  localparam int LEVEL_W   = 3;
  localparam int NUM_LINES = (1 << LEVEL_W) - 1;

  typedef enum logic [1:0] {
    ID_RAW      = 2'd0,
    ID_USER_EVT = 2'd1,
    ID_NO_CAUSE = 2'd2,
    ID_REQ_TRUE = 2'd3
  } idKind_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ANSWER = 2'd1,
    ST_PASS   = 2'd2
  } ackState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic captureId;   // latch status/ID and enable the data lines
    logic releaseBus;  // clear the data lines
  } dpStrobe_t;

endpackage

// File: rtl/ackchain_ctrl.sv
module ackchain_ctrl
  import ackchain_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [LEVEL_W-1:0] levelCfg,
  input  logic               reqStrobe,
  input  logic               iackInN,
  input  logic [LEVEL_W-1:0] ackLevel,
  output logic               pending,
  output dpStrobe_t          strobe,
  output logic               dtackN,
  output logic               iackOutN
);

  ackState_e state;
  logic      heldReq;
  logic      iackActive;
  logic      levelOn;
  logic      claimHit;

  assign iackActive = !iackInN;
  assign levelOn    = (levelCfg != '0);
  assign claimHit   = pending && levelOn && (ackLevel == levelCfg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pending <= 1'b0;
      heldReq <= 1'b0;
    end else if (iackActive) begin
      // Requests during a cycle wait for its release
      heldReq <= heldReq | reqStrobe;
      if (state == ST_IDLE) begin
        if (claimHit) begin
          state   <= ST_ANSWER;
          pending <= 1'b0;
        end else begin
          state <= ST_PASS;
        end
      end
    end else begin
      state   <= ST_IDLE;
      pending <= pending | heldReq | reqStrobe;
      heldReq <= 1'b0;
    end
  end

  always_comb begin
    strobe.captureId  = iackActive && (state == ST_IDLE) && claimHit;
    strobe.releaseBus = !iackActive;
  end

  assign dtackN   = (state != ST_ANSWER);
  assign iackOutN = (state != ST_PASS);

endmodule

// File: rtl/ackchain_dp.sv
module ackchain_dp
  import ackchain_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LEVEL_W-1:0] levelCfg,
  input  logic               pending,
  input  dpStrobe_t          strobe,
  input  logic [7:0]         logicalAddr,
  input  logic [7:0]         causeCode,
  input  logic [5:0]         eventCode,
  input  logic [1:0]         idKind,
  input  logic [15:0]        upperWord,
  output logic [NUM_LINES-1:0] irqN,
  output logic [DATA_W-1:0]  dataOut,
  output logic               dataOe
);

  logic [7:0]        causeByte;
  logic [DATA_W-1:0] idWord;
  logic [DATA_W-1:0] dataReg;
  logic              oeReg;

  always_comb begin
    unique case (idKind_e'(idKind))
      ID_RAW:      causeByte = causeCode;
      ID_USER_EVT: causeByte = {2'b10, eventCode};
      ID_NO_CAUSE: causeByte = 8'hFF;
      default:     causeByte = 8'hFD;
    endcase
  end

  generate
    if (DATA_W == 8) begin : g_w8
      assign idWord = logicalAddr;
    end else if (DATA_W == 16) begin : g_w16
      assign idWord = {causeByte, logicalAddr};
    end else begin : g_w32
      assign idWord = {upperWord, causeByte, logicalAddr};
    end
  endgenerate

  // One request line per level
  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      assign irqN[i] = !(pending && (levelCfg == LEVEL_W'(i + 1)));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      oeReg   <= 1'b0;
    end else if (strobe.releaseBus) begin
      dataReg <= '0;
      oeReg   <= 1'b0;
    end else if (strobe.captureId) begin
      dataReg <= idWord;
      oeReg   <= 1'b1;
    end
  end

  assign dataOut = dataReg;
  assign dataOe  = oeReg;

endmodule

// File: rtl/ackchain_interrupter.sv
module ackchain_interrupter
  import ackchain_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        levelCfg,
  input  logic [7:0]        logicalAddr,
  input  logic [7:0]        causeCode,
  input  logic [5:0]        eventCode,
  input  logic [1:0]        idKind,
  input  logic [15:0]       upperWord,
  input  logic              reqStrobe,
  input  logic              iackInN,
  input  logic [2:0]        ackLevel,
  output logic [6:0]        irqN,
  output logic              iackOutN,
  output logic              dtackN,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  logic      pending;
  dpStrobe_t strobe;

  ackchain_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .levelCfg  (levelCfg),
    .reqStrobe (reqStrobe),
    .iackInN   (iackInN),
    .ackLevel  (ackLevel),
    .pending   (pending),
    .strobe    (strobe),
    .dtackN    (dtackN),
    .iackOutN  (iackOutN)
  );

  ackchain_dp #(.DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .levelCfg    (levelCfg),
    .pending     (pending),
    .strobe      (strobe),
    .logicalAddr (logicalAddr),
    .causeCode   (causeCode),
    .eventCode   (eventCode),
    .idKind      (idKind),
    .upperWord   (upperWord),
    .irqN        (irqN),
    .dataOut     (dataOut),
    .dataOe      (dataOe)
  );

endmodule

// File: rtl/ackchain_checker.sv
module ackchain_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        levelCfg,
  input logic              iackInN,
  input logic [6:0]        irqN,
  input logic              iackOutN,
  input logic              dtackN,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOe
);

  a_r2_single_line: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~irqN) <= 1);

  a_r3_claim_blocks_chain: assert property (@(posedge clk) disable iff (!rstN)
    !dtackN |-> (iackOutN && dataOe));

  a_r4_pass_needs_input: assert property (@(posedge clk) disable iff (!rstN)
    !iackOutN |-> $past(!iackInN));

  a_r5_line_dropped: assert property (@(posedge clk) disable iff (!rstN)
    !dtackN |-> (&irqN));

  a_r7_release: assert property (@(posedge clk) disable iff (!rstN)
    $past(iackInN) |-> (dtackN && iackOutN && !dataOe && (dataOut == '0)));

  a_r9_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (levelCfg == 3'd0) |-> (&irqN));

  a_r10_claim_frozen: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!dtackN) && $past(!iackInN)) |-> !dtackN);

  a_r10_pass_frozen: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!iackOutN) && $past(!iackInN)) |-> !iackOutN);

endmodule

bind ackchain_interrupter ackchain_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .levelCfg (levelCfg),
  .iackInN  (iackInN),
  .irqN     (irqN),
  .iackOutN (iackOutN),
  .dtackN   (dtackN),
  .dataOut  (dataOut),
  .dataOe   (dataOe)
);

// File: tb/tb_ackchain_interrupter.sv
`timescale 1ns/1ps
module tb_ackchain_interrupter;

  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN;
  logic [2:0]    levelCfg;
  logic [7:0]    logicalAddr, causeCode;
  logic [5:0]    eventCode;
  logic [1:0]    idKind;
  logic [15:0]   upperWord;
  logic          reqStrobe, iackInN;
  logic [2:0]    ackLevel;
  logic [6:0]    irqN;
  logic          iackOutN, dtackN, dataOe;
  logic [DW-1:0] dataOut;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  ackchain_interrupter #(.DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .levelCfg(levelCfg), .logicalAddr(logicalAddr),
    .causeCode(causeCode), .eventCode(eventCode), .idKind(idKind),
    .upperWord(upperWord), .reqStrobe(reqStrobe), .iackInN(iackInN),
    .ackLevel(ackLevel), .irqN(irqN), .iackOutN(iackOutN), .dtackN(dtackN),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  // Reference model: 0 idle, 1 claimed, 2 forwarded
  int            mPend = 0;
  int            mHeld = 0;
  int            mSt = 0;
  logic [DW-1:0] mData = '0;

  function automatic logic [DW-1:0] expectId();
    logic [7:0] c;
    case (idKind)
      2'd0: c = causeCode;
      2'd1: c = 8'h80 | {2'b00, eventCode};
      2'd2: c = 8'hFF;
      default: c = 8'hFD;
    endcase
    return {upperWord, c, logicalAddr};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mPend = 0; mHeld = 0; mSt = 0; mData = '0;
    end else if (!iackInN) begin
      if (reqStrobe) mHeld = 1;
      if (mSt == 0) begin
        if (mPend != 0 && levelCfg != 0 && ackLevel == levelCfg) begin
          mSt = 1; mData = expectId(); mPend = 0;
        end else begin
          mSt = 2;
        end
      end
    end else begin
      mSt = 0;
      if (mHeld != 0 || reqStrobe) mPend = 1;
      mHeld = 0;
    end
  end

  // Every-clock comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      logic [6:0] eIrq;
      eIrq = 7'h7F;
      if (mPend != 0 && levelCfg != 0) eIrq[levelCfg - 3'd1] = 1'b0;
      chk("R2 model irqN", 64'(irqN), 64'(eIrq));
      chk("R3 model dtackN", 64'(dtackN), 64'(mSt != 1));
      chk("R4 model iackOutN", 64'(iackOutN), 64'(mSt != 2));
      chk("R6 model dataOut", 64'(dataOut), 64'((mSt == 1) ? mData : '0));
      chk("R7 model dataOe", 64'(dataOe), 64'(mSt == 1));
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    wait (cycles > 20000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
    finish();
  end

  initial begin
    rstN = 1'b0; levelCfg = 3'd3; logicalAddr = 8'h5A; causeCode = 8'h3C;
    eventCode = 6'h15; idKind = 2'd0; upperWord = 16'hBEEF;
    reqStrobe = 1'b0; iackInN = 1'b1; ackLevel = 3'd0;
    step(3);
    // R1 reset state
    chk("R1 irqN", 64'(irqN), 64'h7F);
    chk("R1 dtackN/iackOutN/oe", 64'({dtackN, iackOutN, dataOe}), 64'b110);
    chk("R1 dataOut", 64'(dataOut), 64'h0);
    rstN = 1'b1;
    step();

    // R2 strobe raises level-3 line
    reqStrobe = 1'b1; step(); reqStrobe = 1'b0;
    chk("R2 level 3 line", 64'(irqN), 64'b1111011);
    step(2);

    // R4 mismatch forwards
    ackLevel = 3'd5; iackInN = 1'b0; step();
    chk("R4 forward on mismatch", 64'({iackOutN, dtackN}), 64'b01);
    chk("R4 line kept", 64'(irqN), 64'b1111011);
    step(); iackInN = 1'b1; step();
    chk("R7 forward released", 64'(iackOutN), 64'h1);

    // R3/R5/R6 claim
    ackLevel = 3'd3; iackInN = 1'b0; step();
    chk("R3 claim dtackN", 64'({dtackN, iackOutN, dataOe}), 64'b011);
    chk("R6 raw id", 64'(dataOut), 64'hBEEF3C5A);
    chk("R5 line released", 64'(irqN), 64'h7F);
    // R10 and R8: mid-cycle changes
    ackLevel = 3'd5; reqStrobe = 1'b1; step(); reqStrobe = 1'b0;
    chk("R10 claim held", 64'({dtackN, iackOutN}), 64'b01);
    chk("R8 no line during cycle", 64'(irqN), 64'h7F);
    step(); iackInN = 1'b1; step();
    chk("R7 claim released", 64'({dtackN, dataOe, dataOut}), {31'h0, 1'b1, 1'b0, 32'h0});
    chk("R8 deferred request", 64'(irqN), 64'b1111011);

    // R6 user event
    idKind = 2'd1; ackLevel = 3'd3; iackInN = 1'b0; step();
    chk("R6 user event id", 64'(dataOut), 64'hBEEF955A);
    // R8 strobe on releasing edge
    step(); iackInN = 1'b1; reqStrobe = 1'b1; step(); reqStrobe = 1'b0;
    chk("R8 strobe at release", 64'(irqN), 64'b1111011);

    idKind = 2'd2; iackInN = 1'b0; step();
    chk("R6 no-cause id", 64'(dataOut), 64'hBEEFFF5A);
    iackInN = 1'b1; reqStrobe = 1'b1; step(); reqStrobe = 1'b0;
    idKind = 2'd3; causeCode = 8'h11; logicalAddr = 8'hC3; upperWord = 16'h1234;
    iackInN = 1'b0; step();
    chk("R6 request-true id", 64'(dataOut), 64'h1234FDC3);
    iackInN = 1'b1; step();

    // R4 matching level, nothing pending
    iackInN = 1'b0; step();
    chk("R4 forward without pending", 64'({iackOutN, dtackN}), 64'b01);
    iackInN = 1'b1; step();

    // Strobe on the same edge the cycle starts: forwarded, then pending
    reqStrobe = 1'b1; iackInN = 1'b0; step(); reqStrobe = 1'b0;
    chk("R8 strobe at start forwarded", 64'({iackOutN, dtackN}), 64'b01);
    chk("R8 no line yet", 64'(irqN), 64'h7F);
    step(); iackInN = 1'b1; step();
    chk("R8 pending after release", 64'(irqN), 64'b1111011);

    // R9 level zero
    levelCfg = 3'd0; step();
    chk("R9 no line", 64'(irqN), 64'h7F);
    ackLevel = 3'd0; iackInN = 1'b0; step();
    chk("R9 always forward", 64'({iackOutN, dtackN}), 64'b01);
    iackInN = 1'b1; step();

    // R2 level 7 decode, repeated strobes
    levelCfg = 3'd7; reqStrobe = 1'b1; step(3); reqStrobe = 1'b0;
    chk("R2 level 7 line", 64'(irqN), 64'b0111111);
    ackLevel = 3'd7; iackInN = 1'b0; step();
    chk("R3 claim level 7", 64'(dtackN), 64'h0);
    step(); iackInN = 1'b1; step(2);
    chk("R5 idle after claim", 64'(irqN), 64'h7F);

    finish();
  end

endmodule